// File: doc/BRIEF.md
# Automatic Multi-Byte Serial Transfer Sequencer

This block moves a block of bytes through an external 8-bit serial shift engine with no processor work per byte. It holds a 256-entry byte buffer. Firmware fills the buffer through a host port. It then sets a start offset and a byte count and raises the enable. For each byte, the sequencer does four things in order:

- reads the buffer at the current offset;
- hands that byte to the shift engine with a one-cycle start pulse;
- waits for the engine's done pulse;
- stores the byte the engine received back into the same buffer slot.

The offset then steps forward, wrapping modulo 256, until the count runs out.

Two handshake outputs frame the traffic for the far side of the link: a busy level and a strobe. Both can be framed around every byte or around the whole block, and both follow a selectable active level. The block raises one interrupt pulse, and only after the last received byte sits in the buffer. Dropping the enable abandons the sequence at once.

Top module: `sxfer_auto`

## Requirements
- R1: While reset is high and just after it, `hs_busy` and `hs_strobe` sit at their inactive level (equal to `act_low`), and `irq`, `xfer_busy` and `remaining` are 0.
- R2: The transmit byte for byte k appears on `sh_txd` together with a one-cycle `sh_start` pulse, and equals the buffer content at offset (start + k) mod 256. A new start is issued only after the previous byte's `sh_done`.
- R3: The byte on `sh_rxd` at `sh_done` is written back to the offset its transmit byte came from. Buffer slots outside the block are left unchanged.
- R4: The block length is `count_m1` + 1 bytes (1 to 256), and the offset wraps from 255 to 0.
- R5: `irq` is a single one-cycle pulse per block. It occurs only after the last write-back, when `xfer_busy` is 0 and `remaining` is 0. No pulse occurs for earlier bytes.
- R6: With `frame_block` = 0, the busy output becomes active once per byte: from the buffer read to the write-back. A block of N bytes gives N separate busy intervals.
- R7: With `frame_block` = 1, the busy output is active in one interval covering the whole block.
- R8: The strobe becomes active after a write-back and stays active until the next `sclk_tick`. With `frame_block` = 0 this happens after every byte; with `frame_block` = 1, only after the last. Busy and strobe are never active together.
- R9: With `act_low` = 1 both handshake outputs are active low; with `act_low` = 0 they are active high.
- R10: Driving `enable` low returns the sequencer to idle on the next edge. After that there are no further buffer writes, no interrupt, and both handshake outputs are inactive.
- R11: `xfer_busy` is 1 from the start of a block until its final write-back. `remaining` gives the number of bytes not yet written back (N − k while byte k is in flight).
- R12: One block runs per rising of `enable`. Holding `enable` high after completion starts no further bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low aborts and rearms |
| start_addr | input | 8 | First buffer offset of the block |
| count_m1 | input | 8 | Block length minus one |
| frame_block | input | 1 | 1: handshake framed per block, 0: per byte |
| act_low | input | 1 | 1: handshake outputs active low |
| sclk_tick | input | 1 | One pulse per shift-clock period |
| host_we | input | 1 | Host buffer write strobe |
| host_addr | input | 8 | Host buffer offset |
| host_wdata | input | 8 | Host buffer write data |
| host_rdata | output | 8 | Host buffer read data, one cycle after address |
| sh_start | output | 1 | Start pulse to the shift engine |
| sh_txd | output | 8 | Transmit byte to the shift engine |
| sh_done | input | 1 | Shift engine finished a byte |
| sh_rxd | input | 8 | Received byte, valid with `sh_done` |
| hs_busy | output | 1 | Busy handshake output |
| hs_strobe | output | 1 | Strobe handshake output |
| irq | output | 1 | End-of-block interrupt pulse |
| xfer_busy | output | 1 | Block in progress |
| remaining | output | 9 | Bytes not yet written back |

## Verification
The bench builds the block with its default 8-bit offset and 256-entry buffer. This makes both the full 256-byte block and a block that wraps past offset 255 reachable in short runs. A bench model of the shift engine answers each start after a random delay with the transmit byte XOR 0xA5. The whole buffer image is then compared against a bench copy after every block, including an aborted one.

// File: rtl/sxfer_pkg.sv
package sxfer_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RD     = 3'd1,
    S_LAUNCH = 3'd2,
    S_WAIT   = 3'd3,
    S_WB     = 3'd4,
    S_STB    = 3'd5,
    S_DONE   = 3'd6
  } seq_state_e;
endpackage

// File: rtl/sxfer_ram.sv
module sxfer_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // sequencer port listed last so it wins a same-slot collision
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/sxfer_seq.sv
module sxfer_seq
  import sxfer_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] count_m1,
  input  logic          frame_block,
  input  logic          sclk_tick,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          sh_start,
  output logic [DW-1:0] sh_txd,
  input  logic          sh_done,
  input  logic [DW-1:0] sh_rxd,
  output logic          irq,
  output logic          byte_active,
  output logic          xfer_busy,
  output logic          in_stb,
  output logic [AW:0]   remaining
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  seq_state_e    state;
  logic [AW-1:0] addr;
  logic [CW-1:0] left;
  logic [DW-1:0] rx_q;
  logic          last_byte;

  assign last_byte = (left == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      addr     <= '0;
      left     <= '0;
      rx_q     <= '0;
      sh_start <= 1'b0;
      sh_txd   <= '0;
      irq      <= 1'b0;
    end else begin
      sh_start <= 1'b0;
      irq      <= 1'b0;
      if (!enable) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: begin
            addr  <= start_addr;
            left  <= {1'b0, count_m1} + CW'(1);
            state <= S_RD;
          end
          S_RD: state <= S_LAUNCH;
          S_LAUNCH: begin
            sh_start <= 1'b1;
            sh_txd   <= ram_rdata;
            state    <= S_WAIT;
          end
          S_WAIT: begin
            if (sh_done) begin
              rx_q  <= sh_rxd;
              state <= S_WB;
            end
          end
          S_WB: begin
            left <= left - CW'(1);
            if (last_byte) irq <= 1'b1;
            if (last_byte || !frame_block) begin
              state <= S_STB;
            end else begin
              addr  <= addr + AW'(1);
              state <= S_RD;
            end
          end
          S_STB: begin
            if (sclk_tick) begin
              if (left == '0) begin
                state <= S_DONE;
              end else begin
                addr  <= addr + AW'(1);
                state <= S_RD;
              end
            end
          end
          default: state <= S_DONE;
        endcase
      end
    end
  end

  assign ram_addr    = addr;
  assign ram_we      = enable && (state == S_WB);
  assign ram_wdata   = rx_q;
  assign byte_active = (state == S_RD) || (state == S_LAUNCH) ||
                       (state == S_WAIT) || (state == S_WB);
  assign in_stb      = (state == S_STB);
  assign xfer_busy   = byte_active || (in_stb && (left != '0));
  assign remaining   = left;

  // R2: the start toward the shift engine is a single-cycle pulse
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    sh_start |=> !sh_start);

  // R5: interrupt fires only once the block is fully stored
  p_irq_at_end_r5: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!xfer_busy && remaining == '0));

  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R10: enable low forces idle next cycle
  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (state == S_IDLE && !ram_we));

  // R4: remaining never exceeds the buffer depth
  p_left_range_r4: assert property (@(posedge clk) disable iff (rst)
    remaining <= CW'(DEPTH));

  // R11: a write-back always has a byte outstanding
  p_wb_counted_r11: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> remaining != '0);
endmodule

// File: rtl/sxfer_hs.sv
module sxfer_hs (
  input  logic clk,
  input  logic rst,
  input  logic frame_block,
  input  logic act_low,
  input  logic byte_active,
  input  logic xfer_busy,
  input  logic in_stb,
  output logic hs_busy,
  output logic hs_strobe
);
  logic busy_q;
  logic stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      busy_q <= frame_block ? xfer_busy : byte_active;
      stb_q  <= in_stb;
    end
  end

  // polarity is static configuration, applied after the register
  assign hs_busy   = busy_q ^ act_low;
  assign hs_strobe = stb_q ^ act_low;

  // R8: busy and strobe never overlap
  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && stb_q));
endmodule

// File: rtl/sxfer_auto.sv
module sxfer_auto #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] count_m1,
  input  logic          frame_block,
  input  logic          act_low,
  input  logic          sclk_tick,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          sh_start,
  output logic [DW-1:0] sh_txd,
  input  logic          sh_done,
  input  logic [DW-1:0] sh_rxd,
  output logic          hs_busy,
  output logic          hs_strobe,
  output logic          irq,
  output logic          xfer_busy,
  output logic [AW:0]   remaining
);
  logic [AW-1:0] ram_addr;
  logic          ram_we;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;
  logic          byte_active;
  logic          in_stb;

  sxfer_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk     (clk),
    .a_we    (host_we),
    .a_addr  (host_addr),
    .a_wdata (host_wdata),
    .a_rdata (host_rdata),
    .b_we    (ram_we),
    .b_addr  (ram_addr),
    .b_wdata (ram_wdata),
    .b_rdata (ram_rdata)
  );

  sxfer_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .start_addr  (start_addr),
    .count_m1    (count_m1),
    .frame_block (frame_block),
    .sclk_tick   (sclk_tick),
    .ram_addr    (ram_addr),
    .ram_we      (ram_we),
    .ram_wdata   (ram_wdata),
    .ram_rdata   (ram_rdata),
    .sh_start    (sh_start),
    .sh_txd      (sh_txd),
    .sh_done     (sh_done),
    .sh_rxd      (sh_rxd),
    .irq         (irq),
    .byte_active (byte_active),
    .xfer_busy   (xfer_busy),
    .in_stb      (in_stb),
    .remaining   (remaining)
  );

  sxfer_hs u_hs (
    .clk         (clk),
    .rst         (rst),
    .frame_block (frame_block),
    .act_low     (act_low),
    .byte_active (byte_active),
    .xfer_busy   (xfer_busy),
    .in_stb      (in_stb),
    .hs_busy     (hs_busy),
    .hs_strobe   (hs_strobe)
  );
endmodule

// File: tb/sxfer_auto_tb.sv
module sxfer_auto_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [7:0] start_addr = '0;
  logic [7:0] count_m1 = '0;
  logic       frame_block = 1'b0;
  logic       act_low = 1'b0;
  logic       sclk_tick = 1'b0;
  logic       host_we = 1'b0;
  logic [7:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       sh_start;
  logic [7:0] sh_txd;
  logic       sh_done = 1'b0;
  logic [7:0] sh_rxd = '0;
  logic       hs_busy, hs_strobe, irq, xfer_busy;
  logic [8:0] remaining;

  sxfer_auto u_dut (
    .clk(clk), .rst(rst), .enable(enable), .start_addr(start_addr),
    .count_m1(count_m1), .frame_block(frame_block), .act_low(act_low),
    .sclk_tick(sclk_tick), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sh_start(sh_start),
    .sh_txd(sh_txd), .sh_done(sh_done), .sh_rxd(sh_rxd), .hs_busy(hs_busy),
    .hs_strobe(hs_strobe), .irq(irq), .xfer_busy(xfer_busy),
    .remaining(remaining)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nchk = 0, nfail = 0, cycles = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] exp_addr, last_tx;
  int nstart, nbusy, nstb, nirq, cur_n, dly, tick_cnt;
  bit pend, bact_prev, sact_prev;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rx_of(input logic [7:0] tx);
    return tx ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  // free-running shift clock tick, driven away from the active edge
  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % 4;
    sclk_tick = (tick_cnt == 0);
  end

  // monitor + shift engine model
  always @(negedge clk) begin
    if (!rst) begin
      bit ba, sa;
      ba = hs_busy ^ act_low;
      sa = hs_strobe ^ act_low;
      if (ba && !bact_prev) nbusy++;
      if (sa && !sact_prev) nstb++;
      bact_prev = ba;
      sact_prev = sa;
      if (irq) begin
        nirq++;
        chk(!xfer_busy && remaining == 0 && nstart == cur_n, "R5 irq after last wb",
            int'(remaining), 0);
      end
      sh_done = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          sh_done = 1'b1;
          sh_rxd = rx_of(last_tx);
          pend = 0;
        end else dly--;
      end
      if (sh_start) begin
        chk(!pend, "R2 start before done", 1, 0);
        chk(sh_txd == exp_mem[exp_addr], "R2 txd matches buffer", int'(sh_txd),
            int'(exp_mem[exp_addr]));
        chk(xfer_busy && remaining == 9'(cur_n - nstart), "R11 remaining in flight",
            int'(remaining), cur_n - nstart);
        last_tx = sh_txd;
        pend = 1;
        dly = $urandom_range(0, 3);
        exp_addr = exp_addr + 8'd1;
        nstart++;
      end
    end
  end

  task automatic scan_ram(input string tag);
    int bad = 0, first = -1;
    logic [7:0] got = '0;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      host_addr = 8'(a);
      @(negedge clk);
      if (host_rdata !== exp_mem[a]) begin
        bad++;
        if (first < 0) begin first = a; got = host_rdata; end
      end
    end
    chk(bad == 0, tag, bad, 0);
    if (bad != 0) $display("  first bad slot %0d got %0d", first, got);
  endtask

  task automatic run_xfer(input int sa, input int n, input bit blk, input bit pol,
                          input int abort_at);
    int guard = 0;
    @(negedge clk);
    start_addr = 8'(sa); count_m1 = 8'(n - 1); frame_block = blk; act_low = pol;
    @(negedge clk);
    chk(hs_busy == pol && hs_strobe == pol, "R9 idle level", int'(hs_busy), int'(pol));
    cur_n = n; exp_addr = 8'(sa); nstart = 0; nbusy = 0; nstb = 0; nirq = 0;
    bact_prev = 0; sact_prev = 0;
    enable = 1'b1;
    if (abort_at > 0) begin
      do begin @(negedge clk); #1; guard++; end while (nstart < abort_at && guard < 20000);
      enable = 1'b0;
      for (int k = 0; k < abort_at - 1; k++) exp_mem[8'(sa + k)] = rx_of(exp_mem[8'(sa + k)]);
      repeat (30) @(negedge clk);
      #1;
      chk(nirq == 0, "R10 no irq after abort", nirq, 0);
      chk(!xfer_busy && hs_busy == pol && hs_strobe == pol, "R10 idle after abort",
          int'(xfer_busy), 0);
      chk(nstart == abort_at, "R10 no further bytes", nstart, abort_at);
      scan_ram("R10 buffer after abort");
      return;
    end
    do begin @(negedge clk); #1; guard++; end while (nirq == 0 && guard < 20000);
    for (int k = 0; k < n; k++) exp_mem[8'(sa + k)] = rx_of(exp_mem[8'(sa + k)]);
    repeat (25) @(negedge clk);
    #1;
    chk(nirq == 1, "R5 single irq", nirq, 1);
    chk(nstart == n, "R12 no restart while enabled / R4 length", nstart, n);
    chk(nbusy == (blk ? 1 : n), blk ? "R7 block busy intervals" : "R6 byte busy intervals",
        nbusy, blk ? 1 : n);
    chk(nstb == (blk ? 1 : n), "R8 strobe count", nstb, blk ? 1 : n);
    chk(!xfer_busy && remaining == 0, "R11 idle after block", int'(remaining), 0);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    scan_ram("R3 R4 buffer image");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick_cnt = 0; pend = 0; dly = 0;
    repeat (3) @(negedge clk);
    chk(hs_busy == 1'b0 && hs_strobe == 1'b0 && irq == 1'b0, "R1 reset outputs",
        int'(hs_busy), 0);
    chk(!xfer_busy && remaining == 0, "R1 reset status", int'(remaining), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(hs_busy == 1'b0 && !xfer_busy && !irq, "R1 after reset", int'(xfer_busy), 0);
    for (int a = 0; a < 256; a++) begin
      host_we = 1'b1; host_addr = 8'(a); host_wdata = 8'($urandom);
      exp_mem[a] = host_wdata;
      @(negedge clk);
    end
    host_we = 1'b0;
    run_xfer(0, 1, 1'b0, 1'b0, 0);
    run_xfer(250, 10, 1'b1, 1'b1, 0);
    run_xfer(77, 256, 1'b1, 1'b0, 0);
    run_xfer(3, 12, 1'b0, 1'b1, 0);
    for (int r = 0; r < 4; r++)
      run_xfer($urandom_range(0, 255), $urandom_range(1, 40), 1'($urandom), 1'($urandom), 0);
    run_xfer(200, 20, 1'b0, 1'b0, 5);
    run_xfer(10, 8, 1'b1, 1'b0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule